// File: doc/BRIEF.md
# Control-Pulse Edge Capture and Duty Classifier

This block timestamps and classifies a slow control-track pulse train. A 16-bit free-running timer advances once per prescaler tick, where the prescaler divides the system clock by 2, 4, 8, 12, 16 or 24. The pulse input is asynchronous. It passes through a two-stage synchroniser before edge detection. On each edge that the edge-select field names, the current timer value is captured and handed out on a valid/ready stream, and an edge interrupt pulses.

Every synchronised rising edge after the first one closes one full period. At that edge the high time of the closed period is compared against a programmable fraction of its length, which gives one duty bit. The duty bit is pushed into an 8-bit pattern register. The new pattern is compared with a programmable match value, and a 4-bit pulse counter steps down. When the counter underflows it reloads from a programmable value. Firmware uses the pattern match and the counter underflow to find index marks and to count pulses.

The capture stream follows these back-pressure rules:
- A transfer occurs in any cycle where `cap_valid` and `cap_ready` are both high.
- While a word waits, `cap_valid` stays high and `cap_value` does not change.
- A new capture edge that arrives while a word waits replaces that word with the newer timestamp, and `cap_valid` stays high. The stream therefore always holds the newest edge and never stalls the timer.

Top module: `ctl_pulse_timer`

## Requirements
- R1: `ctl_in` is sampled by two flip-flops, and the edge detector uses the second flip-flop and its delayed copy. `edge_sel` picks the capture edge: 0 selects rising, 1 selects falling, and 2 or 3 select both. In the clock edge where a selected edge is detected, `irq_edge` pulses for one cycle and `cap_value` loads the timer value as it stood before that clock edge.
- R2: The prescaler ratio is chosen by `div_sel`: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /12, 4 gives /16 and 5 gives /24. Codes 6 and 7 act as /2. The timer increases by exactly 1 once per prescaler tick, and `timer_value` shows it.
- R3: When a tick occurs with the timer at 16'hFFFF, the timer wraps to 0 and `irq_ovf` pulses for one cycle in the same clock edge.
- R4: `cap_valid` rises on a capture. It falls only after a cycle with `cap_ready` high and no new capture. While `cap_valid` is high and `cap_ready` is low, `cap_value` holds unless a new capture overwrites it.
- R5: Call the synchronised level S. At each rising edge of S, P is the number of cycles since the previous rising edge of S, and H is the number of those cycles in which S was high. The duty bit is 1 when H*16 > `duty_thr`*P, and 0 otherwise.
- R6: A judged pulse shifts `pat_shift` left by one. The new duty bit enters bit 0.
- R7: `irq_match` pulses for one cycle, in the same clock edge as a judged pulse, when the shifted pattern equals `match_pat`.
- R8: Each judged pulse decrements `pulse_left`. A judged pulse that finds `pulse_left` at 0 pulses `irq_unf` and loads `pulse_left` from `pulse_reload`.
- R9: While `rst_n` is low, these outputs are all 0: the timer, the capture value and its valid flag, `pat_shift`, `pulse_left`, and all four interrupts.
- R10: The first rising edge of S after reset only starts period measurement. It produces no duty bit, no shift and no counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_in | input | 1 | Asynchronous control pulse |
| div_sel | input | 3 | Prescaler ratio select |
| edge_sel | input | 2 | Capture edge select |
| duty_thr | input | 4 | Duty threshold in sixteenths of the period |
| match_pat | input | 8 | Pattern compare value |
| pulse_reload | input | 4 | Pulse counter reload value |
| cap_ready | input | 1 | Capture stream ready |
| cap_valid | output | 1 | Capture stream valid |
| cap_value | output | 16 | Captured timer value |
| timer_value | output | 16 | Current timer count |
| pat_shift | output | 8 | Duty-bit pattern register |
| pulse_left | output | 4 | Pulse down-counter |
| irq_ovf | output | 1 | Timer overflow pulse |
| irq_edge | output | 1 | Capture edge pulse |
| irq_unf | output | 1 | Pulse counter underflow pulse |
| irq_match | output | 1 | Pattern match pulse |

## Verification
The assertions assume that the configuration inputs are quasi-static, so one cycle of `$past` on `match_pat` and `pulse_reload` stands for the value used at the shift. They also assume that `cap_ready` is a plain level sampled at the clock. The stimulus changes configuration and `ctl_in` only at falling clock edges, and it holds each setting for whole pulse trains. It toggles `cap_ready` pseudo-randomly, so both held and drained capture words occur. Pulse trains place the high time on both sides of the threshold and exactly on it, and a long run at /2 carries the timer through its wrap.

// File: rtl/ctl_pulse_pkg.sv
package ctl_pulse_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;

  localparam int DIV_W = 5;

  // Prescaler ratio for each select code; unused codes fall back to /2.
  function automatic logic [DIV_W-1:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    div_ratio = 5'd2;
      3'd1:    div_ratio = 5'd4;
      3'd2:    div_ratio = 5'd8;
      3'd3:    div_ratio = 5'd12;
      3'd4:    div_ratio = 5'd16;
      3'd5:    div_ratio = 5'd24;
      default: div_ratio = 5'd2;
    endcase
  endfunction

endpackage

// File: rtl/ctl_sync_edge.sv
module ctl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign level = stage_q[STAGES-1];
  assign rise  = stage_q[STAGES-1] & ~prev_q;
  assign fall  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ctl_prescale_timer.sv
module ctl_prescale_timer
  import ctl_pulse_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    div_sel,
  output logic [TW-1:0] count_q,
  output logic          ovf_q
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             tick;

  assign div_last = div_ratio(div_sel) - 5'd1;
  // >= so that switching to a smaller ratio never strands the counter
  assign tick     = (div_cnt >= div_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      ovf_q   <= tick & (&count_q);
      if (tick) count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_duty_judge.sv
module ctl_duty_judge #(
  parameter int CW   = 16,
  parameter int TH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level,
  input  logic            rise,
  input  logic [TH_W-1:0] thr,
  output logic            judge,
  output logic            duty_bit
);
  localparam int PW = CW + TH_W;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] per_cnt;
  logic [CW-1:0] hi_cnt;
  logic          primed;
  logic [PW-1:0] hi_scaled;
  logic [PW-1:0] per_scaled;

  assign hi_scaled  = {hi_cnt, {TH_W{1'b0}}};
  assign per_scaled = PW'(per_cnt) * PW'(thr);
  assign judge      = rise & primed;
  assign duty_bit   = hi_scaled > per_scaled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
      primed  <= 1'b0;
    end else if (rise) begin
      per_cnt <= CW'(1);
      hi_cnt  <= CW'(1);
      primed  <= 1'b1;
    end else begin
      if (per_cnt != CMAX)          per_cnt <= per_cnt + 1'b1;
      if (level && hi_cnt != CMAX)  hi_cnt  <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_pattern_count.sv
module ctl_pattern_count #(
  parameter int SR_W = 8,
  parameter int PC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            judge,
  input  logic            duty_bit,
  input  logic [SR_W-1:0] cmp_val,
  input  logic [PC_W-1:0] reload,
  output logic [SR_W-1:0] pat_q,
  output logic [PC_W-1:0] cnt_q,
  output logic            match_q,
  output logic            unf_q
);
  logic [SR_W-1:0] pat_next;

  assign pat_next = {pat_q[SR_W-2:0], duty_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q   <= '0;
      cnt_q   <= '0;
      match_q <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      match_q <= judge & (pat_next == cmp_val);
      unf_q   <= judge & (cnt_q == '0);
      if (judge) begin
        pat_q <= pat_next;
        cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_pulse_timer.sv
module ctl_pulse_timer
  import ctl_pulse_pkg::*;
#(
  parameter int TW     = 16,
  parameter int SR_W   = 8,
  parameter int PC_W   = 4,
  parameter int TH_W   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_in,
  input  logic [2:0]      div_sel,
  input  logic [1:0]      edge_sel,
  input  logic [TH_W-1:0] duty_thr,
  input  logic [SR_W-1:0] match_pat,
  input  logic [PC_W-1:0] pulse_reload,
  input  logic            cap_ready,
  output logic            cap_valid,
  output logic [TW-1:0]   cap_value,
  output logic [TW-1:0]   timer_value,
  output logic [SR_W-1:0] pat_shift,
  output logic [PC_W-1:0] pulse_left,
  output logic            irq_ovf,
  output logic            irq_edge,
  output logic            irq_unf,
  output logic            irq_match
);
  logic      lvl, rise, fall;
  logic      cap_edge;
  logic      judge, duty_bit;
  edge_sel_e esel;

  ctl_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ctl_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  ctl_prescale_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
    .count_q(timer_value), .ovf_q(irq_ovf)
  );

  ctl_duty_judge #(.CW(TW), .TH_W(TH_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .level(lvl), .rise(rise), .thr(duty_thr),
    .judge(judge), .duty_bit(duty_bit)
  );

  ctl_pattern_count #(.SR_W(SR_W), .PC_W(PC_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .judge(judge), .duty_bit(duty_bit),
    .cmp_val(match_pat), .reload(pulse_reload),
    .pat_q(pat_shift), .cnt_q(pulse_left),
    .match_q(irq_match), .unf_q(irq_unf)
  );

  assign esel = edge_sel_e'(edge_sel);

  always_comb begin
    case (esel)
      EDGE_RISE: cap_edge = rise;
      EDGE_FALL: cap_edge = fall;
      default:   cap_edge = rise | fall;
    endcase
  end

  // Capture stream: newest edge wins; word held until accepted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_value <= '0;
      irq_edge  <= 1'b0;
    end else begin
      irq_edge <= cap_edge;
      if (cap_edge) begin
        cap_valid <= 1'b1;
        cap_value <= timer_value;
      end else if (cap_valid && cap_ready) begin
        cap_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctl_pulse_timer_chk.sv
module ctl_pulse_timer_chk #(
  parameter int TW   = 16,
  parameter int SR_W = 8,
  parameter int PC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SR_W-1:0] match_pat,
  input logic [PC_W-1:0] pulse_reload,
  input logic            cap_ready,
  input logic            cap_valid,
  input logic [TW-1:0]   cap_value,
  input logic [TW-1:0]   timer_value,
  input logic [SR_W-1:0] pat_shift,
  input logic [PC_W-1:0] pulse_left,
  input logic            irq_ovf,
  input logic            irq_edge,
  input logic            irq_unf,
  input logic            irq_match
);
  assert_edge_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |-> (cap_valid && cap_value == $past(timer_value)));

  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_value != $past(timer_value)) |-> (timer_value == TW'($past(timer_value) + 1'b1)));

  assert_ovf_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> (timer_value == '0 && $past(timer_value) == {TW{1'b1}}));

  assert_hold_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> cap_valid);

  assert_hold_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> (irq_edge || $stable(cap_value)));

  assert_shift_in_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_shift != $past(pat_shift)) |-> (pat_shift[SR_W-1:1] == $past(pat_shift[SR_W-2:0])));

  assert_match_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_match |-> (pat_shift == $past(match_pat)));

  assert_unf_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unf |-> ($past(pulse_left) == '0 && pulse_left == $past(pulse_reload)));
endmodule

bind ctl_pulse_timer ctl_pulse_timer_chk #(.TW(TW), .SR_W(SR_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_pat(match_pat), .pulse_reload(pulse_reload),
  .cap_ready(cap_ready), .cap_valid(cap_valid), .cap_value(cap_value),
  .timer_value(timer_value), .pat_shift(pat_shift), .pulse_left(pulse_left),
  .irq_ovf(irq_ovf), .irq_edge(irq_edge), .irq_unf(irq_unf), .irq_match(irq_match)
);

// File: tb/ctl_pulse_timer_test.sv
module ctl_pulse_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_in = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [1:0] edge_sel = 2'd0;
  logic [3:0] duty_thr = 4'd8;
  logic [7:0] match_pat = 8'hA5;
  logic [3:0] pulse_reload = 4'd3;
  logic       cap_ready = 1'b0;

  logic        cap_valid;
  logic [15:0] cap_value, timer_value;
  logic [7:0]  pat_shift;
  logic [3:0]  pulse_left;
  logic        irq_ovf, irq_edge, irq_unf, irq_match;

  ctl_pulse_timer uut (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .div_sel(div_sel),
    .edge_sel(edge_sel), .duty_thr(duty_thr), .match_pat(match_pat),
    .pulse_reload(pulse_reload), .cap_ready(cap_ready),
    .cap_valid(cap_valid), .cap_value(cap_value), .timer_value(timer_value),
    .pat_shift(pat_shift), .pulse_left(pulse_left), .irq_ovf(irq_ovf),
    .irq_edge(irq_edge), .irq_unf(irq_unf), .irq_match(irq_match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  int n_ovf = 0, n_match = 0, n_unf = 0;

  // Behavioural reference state
  int m1, m2, m3;
  int e_tmr, e_div, e_cv, e_cval, e_sr, e_pc;
  int e_iovf, e_iedge, e_iunf, e_imatch;
  int per, hi, primed;

  function automatic int ratio_of(int sel);
    case (sel)
      1: return 4;
      2: return 8;
      3: return 12;
      4: return 16;
      5: return 24;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0;
      e_tmr = 0; e_div = 0; e_cv = 0; e_cval = 0; e_sr = 0; e_pc = 0;
      e_iovf = 0; e_iedge = 0; e_iunf = 0; e_imatch = 0;
      per = 0; hi = 0; primed = 0;
    end else begin
      int rise, fall, cap, tick, bitv;
      rise = (m2 == 1 && m3 == 0);
      fall = (m2 == 0 && m3 == 1);
      cap = (edge_sel == 0) ? rise : (edge_sel == 1) ? fall : (rise || fall);
      if (cap) begin e_cv = 1; e_cval = e_tmr; end
      else if (e_cv == 1 && cap_ready) e_cv = 0;
      e_iedge = cap;
      tick = (e_div >= ratio_of(int'(div_sel)) - 1);
      e_div = tick ? 0 : e_div + 1;
      e_iovf = (tick && e_tmr == 65535);
      if (tick) e_tmr = (e_tmr + 1) % 65536;
      e_imatch = 0; e_iunf = 0;
      if (rise && primed) begin
        bitv = (hi * 16 > int'(duty_thr) * per) ? 1 : 0;
        e_sr = ((e_sr << 1) | bitv) & 255;
        e_imatch = (e_sr == int'(match_pat));
        if (e_pc == 0) begin e_iunf = 1; e_pc = int'(pulse_reload); end
        else e_pc = e_pc - 1;
      end
      if (rise) begin primed = 1; per = 1; hi = 1; end
      else begin
        if (per < 65535) per = per + 1;
        if (m2 == 1 && hi < 65535) hi = hi + 1;
      end
      m3 = m2; m2 = m1; m1 = int'(ctl_in);
    end
  end

  task automatic chk(string tag, string name, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, name, act, exp, cycles);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      n_vec++;
      chk("R2", "timer_value", int'(timer_value), e_tmr);
      chk("R3", "irq_ovf", int'(irq_ovf), e_iovf);
      chk("R1", "irq_edge", int'(irq_edge), e_iedge);
      chk("R4", "cap_valid", int'(cap_valid), e_cv);
      if (e_cv == 1) chk("R1", "cap_value", int'(cap_value), e_cval);
      chk("R6", "pat_shift", int'(pat_shift), e_sr);
      chk("R7", "irq_match", int'(irq_match), e_imatch);
      chk("R8", "pulse_left", int'(pulse_left), e_pc);
      chk("R8", "irq_unf", int'(irq_unf), e_iunf);
      if (irq_ovf) n_ovf++;
      if (irq_match) n_match++;
      if (irq_unf) n_unf++;
      cap_ready <= ($urandom_range(0, 2) != 0);
      if (cycles >= WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int h, int p);
    ctl_in = 1'b1; idle(h);
    ctl_in = 1'b0; idle(p - h);
  endtask

  // One pulse per bit, MSB first: 1 is 75% duty, 0 is 25% at threshold 8/16.
  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i] ? 9 : 3, 12);
  endtask

  initial begin
    idle(4);
    // R9: reset state
    chk("R9", "reset timer", int'(timer_value), 0);
    chk("R9", "reset cap_valid", int'(cap_valid), 0);
    chk("R9", "reset irqs", int'({irq_ovf, irq_edge, irq_unf, irq_match}), 0);
    chk("R9", "reset pat/cnt", int'({pat_shift, pulse_left}), 0);
    rst_n = 1'b1;
    idle(3);
    // R10: the first rise only primes; no shift and no count step
    pulse(5, 10);
    chk("R10", "pattern after first rise", int'(pat_shift), 0);
    chk("R10", "no underflow on first rise", n_unf, 0);
    // R5/R6/R7: feed the match byte so irq_match fires
    send_byte(8'hA5);
    pulse(9, 12);   // closes the last pulse of the byte
    chk("R7", "match seen", int'(n_match > 0), 1);
    chk("R8", "underflow seen", int'(n_unf > 0), 1);
    // R5: threshold boundary (6/12 at 8/16 is equal -> 0, 7/12 -> 1)
    pulse(6, 12); pulse(7, 12); pulse(7, 12);
    chk("R5", "boundary bits", int'(pat_shift[1:0]), 2'b01);
    duty_thr = 4'd0; pulse(1, 9); pulse(1, 9);
    duty_thr = 4'd15; pulse(8, 9); pulse(8, 9);
    duty_thr = 4'd8;
    // R1/R2: every ratio and every edge select
    for (int d = 0; d < 8; d++) begin
      for (int e = 0; e < 4; e++) begin
        div_sel = 3'(d); edge_sel = 2'(e);
        pulse(4 + e, 11 + d); pulse(2, 7); pulse(10, 13);
      end
    end
    // R3: long run at /2 carries the timer through its wrap
    div_sel = 3'd0; edge_sel = 2'd2; pulse_reload = 4'd9;
    for (int k = 0; k < 135; k++) pulse(300 + k, 1000);
    chk("R3", "overflow seen", int'(n_ovf > 0), 1);
    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule